// File: doc/BRIEF.md
# Prescaled Timer and Falling-Edge Event Counter

This block is the 8-bit count unit of a small embedded controller. Firmware picks its clock source at run time. The internal source is the controller's instruction-cycle strobe passed through a divide-by-32 prescaler. The external source is a pin whose falling edges are counted. Both sources feed one up-counter. Overflow handling is the same in both modes. Every roll-over from the top value to zero sets a sticky overflow flag and, when enabled, raises a level interrupt request.

Three single-cycle commands drive the block: start as timer, start as event counter, and stop. The prescaler runs freely on every strobe. Only hardware reset or a start-as-timer command clears it. Stopping the counter, starting it as an event counter, or loading it leaves the prescaler phase alone. The count can be read at any time and written through a parallel load port.

Top module: `tec_top`

## Requirements
- R1: After reset the counter is stopped, the count and the prescaler are zero, and both the overflow flag and the interrupt request are low.
- R2: The count is CNT_W bits wide. Each counting event adds exactly one, and the count wraps from all-ones to zero. In any cycle with no counting event and no load, the count holds its value.
- R3: In timer mode the prescaler advances on every cycle in which the strobe is high and produces one tick per 32 strobes. Each tick adds one to the count. After a start-as-timer command, the 32nd strobe in the cycles after the command produces the first increment. A strobe in the command cycle itself is not counted.
- R4: A start-as-timer command clears the prescaler. Stop, start-as-event-counter and parallel loads leave the prescaler phase unchanged.
- R5: In event mode the pin passes through two synchronizing flops. A high-to-low change is counted once. If the pin falls before rising edge k, the count changes at edge k+2. Rising edges are not counted.
- R6: While the counter is stopped, neither strobes nor pin edges change the count, in either mode.
- R7: Commands take effect at the next cycle, so counting in the command cycle follows the previous state. When commands coincide, stop has the highest priority, then start-as-timer, then start-as-event-counter.
- R8: A load writes the supplied value into the count at the next edge. A load beats an increment in the same cycle, and that increment raises no overflow.
- R9: A roll-over from all-ones to zero sets the overflow flag, which stays set until a clear. A clear in the same cycle as an overflow leaves the flag set.
- R10: With the enable high, an overflow raises the interrupt request, which stays high until acknowledged. An overflow in the same cycle as an acknowledge keeps the request high. When the enable goes low, the request drops at the next edge, and an overflow that occurs while the enable is low never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| cmd_start_tmr | input | 1 | Pulse: run counter from prescaled strobe, clear prescaler |
| cmd_start_evt | input | 1 | Pulse: run counter from falling pin edges |
| cmd_stop | input | 1 | Pulse: halt counting |
| ic_stb | input | 1 | Instruction-cycle strobe |
| ev_pin | input | 1 | Asynchronous external event input |
| ld_en | input | 1 | Parallel load strobe |
| ld_val | input | CNT_W | Value to load |
| cnt_q | output | CNT_W | Current count |
| ovf_clr | input | 1 | Clear overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_req | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit count, a divide-by-32 prescaler and two synchronizer stages. These values give the exact cycle positions of the first timer tick and of an edge-driven increment, which the directed cases check. Loads of values close to 0xFF bring roll-over within a few strobes or pin edges, so overflow coinciding with a clear, an acknowledge, a load, a command or a disable occurs many times during the random phase.

// File: rtl/tec_pkg.sv
package tec_pkg;
  typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} src_e;

  // next value of a modulo counter
  function automatic logic [31:0] mod_inc(input logic [31:0] v, input longint unsigned modulus);
    mod_inc = (longint'(v) + 1 >= modulus) ? 32'd0 : v + 32'd1;
  endfunction

  // true when v is the last value before wrap
  function automatic logic mod_last(input logic [31:0] v, input longint unsigned modulus);
    mod_last = (longint'(v) + 1 >= modulus);
  endfunction
endpackage

// File: rtl/tec_prescaler.sv
module tec_prescaler #(
  parameter int unsigned DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic stb_i,
  output logic tick_o
);
  import tec_pkg::*;
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre_q;

  assign tick_o = stb_i & ~clr_i & mod_last(32'(pre_q), DIV);

  always_ff @(posedge clk) begin
    if (!rst_n)      pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (stb_i)  pre_q <= PW'(mod_inc(32'(pre_q), DIV));
  end

  AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> pre_q == '0); // R4
  AST_PRE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !stb_i) |=> $stable(pre_q)); // R3
endmodule

// File: rtl/tec_fall_sync.sv
module tec_fall_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[g] <= 1'b1;
        else        sync_q[g] <= (g == 0) ? pin_i : sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= sync_q[STAGES-1];
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o); // R5
endmodule

// File: rtl/tec_flags.sv
module tec_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_i,
  input  logic clr_i,
  input  logic en_i,
  input  logic ack_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      flag_o <= ovf_i | (flag_o & ~clr_i);
      irq_o  <= en_i & (ovf_i | (irq_o & ~ack_i));
    end
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_i |=> flag_o); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o); // R9
  AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !irq_o); // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(ovf_i)); // R10
endmodule

// File: rtl/tec_top.sv
module tec_top #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned PRE_DIV     = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start_tmr,
  input  logic             cmd_start_evt,
  input  logic             cmd_stop,
  input  logic             ic_stb,
  input  logic             ev_pin,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt_q,
  input  logic             ovf_clr,
  output logic             ovf_flag,
  input  logic             irq_en,
  input  logic             irq_ack,
  output logic             irq_req
);
  import tec_pkg::*;
  localparam longint unsigned CNT_MOD = longint'(1) << CNT_W;

  logic run_q;
  src_e src_q;
  logic pre_tick;
  logic ev_fall;
  logic inc_evt;
  logic ovf_evt;

  tec_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr_i(cmd_start_tmr), .stb_i(ic_stb), .tick_o(pre_tick)
  );

  tec_fall_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ev_pin), .fall_o(ev_fall)
  );

  // run state and clock source; stop > start timer > start event
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      src_q <= SRC_INT;
    end else if (cmd_stop) begin
      run_q <= 1'b0;
    end else if (cmd_start_tmr) begin
      run_q <= 1'b1;
      src_q <= SRC_INT;
    end else if (cmd_start_evt) begin
      run_q <= 1'b1;
      src_q <= SRC_EXT;
    end
  end

  assign inc_evt = run_q & ((src_q == SRC_INT) ? pre_tick : ev_fall);
  assign ovf_evt = inc_evt & ~ld_en & mod_last(32'(cnt_q), CNT_MOD);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (ld_en)   cnt_q <= ld_val;
    else if (inc_evt) cnt_q <= CNT_W'(mod_inc(32'(cnt_q), CNT_MOD));
  end

  tec_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ovf_i(ovf_evt), .clr_i(ovf_clr),
    .en_i(irq_en), .ack_i(irq_ack), .flag_o(ovf_flag), .irq_o(irq_req)
  );

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> cnt_q == $past(ld_val)); // R8
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_evt && !ld_en) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_evt && !ld_en) |=> $stable(cnt_q)); // R2
  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !ld_en) |=> $stable(cnt_q)); // R6
  AST_STOP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> !run_q); // R7
endmodule

// File: tb/test_tec_top.sv
module test_tec_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start_tmr = 0, cmd_start_evt = 0, cmd_stop = 0;
  logic ic_stb = 0, ev_pin = 1, ld_en = 0, ovf_clr = 0, irq_en = 0, irq_ack = 0;
  logic [7:0] ld_val = 0;
  logic [7:0] cnt_q;
  logic ovf_flag, irq_req;

  int n_cmp = 0, n_bad = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  tec_top i_tec_top (
    .clk(clk), .rst_n(rst_n), .cmd_start_tmr(cmd_start_tmr), .cmd_start_evt(cmd_start_evt),
    .cmd_stop(cmd_stop), .ic_stb(ic_stb), .ev_pin(ev_pin), .ld_en(ld_en), .ld_val(ld_val),
    .cnt_q(cnt_q), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .irq_en(irq_en),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  // ---- reference model, written from the requirements ----
  logic [7:0] m_cnt;
  logic [4:0] m_pre;
  logic m_run, m_tmr, m_flag, m_irq, m_s1, m_s2, m_s3;

  always @(posedge clk) begin
    logic fall, tick, inc, ovf;
    if (!rst_n) begin
      m_cnt <= 0; m_pre <= 0; m_run <= 0; m_tmr <= 1; m_flag <= 0; m_irq <= 0;
      m_s1 <= 1; m_s2 <= 1; m_s3 <= 1;
    end else begin
      fall = m_s3 && !m_s2;
      tick = ic_stb && m_pre == 5'd31 && !cmd_start_tmr;
      inc  = m_run && (m_tmr ? tick : fall);
      ovf  = inc && !ld_en && m_cnt == 8'hFF;
      m_s1 <= ev_pin; m_s2 <= m_s1; m_s3 <= m_s2;
      if (cmd_start_tmr) m_pre <= 0; else if (ic_stb) m_pre <= m_pre + 1;
      if (ld_en) m_cnt <= ld_val; else if (inc) m_cnt <= m_cnt + 1;
      m_flag <= ovf || (m_flag && !ovf_clr);
      m_irq  <= irq_en && (ovf || (m_irq && !irq_ack));
      if (cmd_stop) m_run <= 0;
      else if (cmd_start_tmr) begin m_run <= 1; m_tmr <= 1; end
      else if (cmd_start_evt) begin m_run <= 1; m_tmr <= 0; end
    end
  end

  function automatic logic [7:0] plus1(input logic [7:0] v);
    return 8'((int'(v) + 1) % 256);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk(cnt_q === m_cnt, {phase, " count"}, cnt_q, m_cnt);
    chk(ovf_flag === m_flag, {phase, " R9 flag"}, ovf_flag, m_flag);
    chk(irq_req === m_irq, {phase, " R10 irq"}, irq_req, m_irq);
  endtask

  // one clock: inputs already set; compare after the edge; drop pulses
  task automatic cyc();
    @(posedge clk); @(negedge clk);
    cmp_all();
    cmd_start_tmr = 0; cmd_start_evt = 0; cmd_stop = 0;
    ld_en = 0; ovf_clr = 0; irq_ack = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] c0;
    int waited;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    phase = "R1";
    chk(cnt_q == 0 && !ovf_flag && !irq_req, "R1 reset state", {cnt_q, ovf_flag, irq_req}, 0);
    ic_stb = 1;
    repeat (40) cyc();
    chk(cnt_q == 0, "R1 stopped after reset", cnt_q, 0);

    // R3: first tick on the 32nd strobe after the command
    phase = "R3"; irq_en = 1;
    cmd_start_tmr = 1; cyc();
    repeat (31) cyc();
    chk(cnt_q == 0, "R3 no tick before 32 strobes", cnt_q, 0);
    cyc();
    chk(cnt_q == 1, "R3 tick on 32nd strobe", cnt_q, 1);

    // R4 / R8: load mid-prescale leaves phase alone
    phase = "R8";
    repeat (10) cyc();
    ld_en = 1; ld_val = 8'h40; cyc();
    chk(cnt_q == 8'h40, "R8 load value", cnt_q, 8'h40);
    waited = 0;
    while (cnt_q == 8'h40 && waited < 60) begin cyc(); waited++; end
    chk(waited == 21, "R4 load keeps prescaler phase", waited, 21);

    // R9 / R10: overflow in timer mode
    phase = "R9";
    ld_en = 1; ld_val = 8'hFF; cyc();
    waited = 0;
    while (cnt_q == 8'hFF && waited < 60) begin cyc(); waited++; end
    chk(cnt_q == 0 && ovf_flag, "R9 wrap sets flag", {cnt_q, ovf_flag}, 1);
    chk(irq_req, "R10 irq on overflow", irq_req, 1);
    ovf_clr = 1; irq_ack = 1; cyc();
    chk(!ovf_flag && !irq_req, "R10 clear and ack", {ovf_flag, irq_req}, 0);

    // R5: edge latency in event mode, set-wins for clear/ack
    phase = "R5"; ic_stb = 0;
    cmd_start_evt = 1; cyc();
    repeat (3) cyc();
    c0 = cnt_q;
    ev_pin = 0; cyc();
    chk(cnt_q == c0, "R5 edge+1 unchanged", cnt_q, c0);
    cyc();
    chk(cnt_q == c0, "R5 edge+2 unchanged", cnt_q, c0);
    cyc();
    chk(cnt_q == plus1(c0), "R5 count at third edge", cnt_q, plus1(c0));
    ev_pin = 1; repeat (5) cyc();
    chk(cnt_q == plus1(c0), "R5 rising edge ignored", cnt_q, plus1(c0));
    ld_en = 1; ld_val = 8'hFF; cyc();
    ev_pin = 0; cyc(); cyc();
    ovf_clr = 1; irq_ack = 1; cyc();
    chk(ovf_flag && irq_req && cnt_q == 0, "R9 R10 set wins over clear", {ovf_flag, irq_req}, 3);
    irq_en = 0; cyc();
    chk(!irq_req && ovf_flag, "R10 disable drops request", irq_req, 0);

    // R6 / R7: stop beats start in the same cycle
    phase = "R7";
    cmd_stop = 1; cmd_start_tmr = 1; cyc();
    c0 = cnt_q; ic_stb = 1;
    for (int i = 0; i < 8; i++) begin ev_pin = ~ev_pin; repeat (10) cyc(); end
    chk(cnt_q == c0, "R6 R7 stopped ignores strobes and edges", cnt_q, c0);

    // random phase, checked every cycle against the model
    phase = "RND R2 R3 R5 R8";
    for (int i = 0; i < 30000; i++) begin
      int r;
      r = $urandom_range(0, 999);
      ic_stb = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 5) == 0) ev_pin = ~ev_pin;
      if (r < 4) cmd_start_tmr = 1;
      else if (r < 8) cmd_start_evt = 1;
      else if (r < 10) cmd_stop = 1;
      if ($urandom_range(0, 199) == 0) cmd_start_evt = 1;
      if ($urandom_range(0, 49) == 0) begin
        ld_en = 1;
        ld_val = ($urandom_range(0, 1) != 0) ? 8'(8'hFF - $urandom_range(0, 3)) : 8'($urandom);
      end
      if ($urandom_range(0, 19) == 0) ovf_clr = 1;
      if ($urandom_range(0, 15) == 0) irq_ack = 1;
      if ($urandom_range(0, 99) == 0) irq_en = ~irq_en;
      cyc();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule